// File: doc/BRIEF.md
# Six-Sector Three-Phase Duty Generator

This block turns an electrical angle into three phase duty words for a brushless motor power stage. The three outputs form a balanced three-phase set that has been shifted and scaled at every angle so that the lowest phase sits at zero and the highest sits at full scale. All modulation is carried by the one phase in between. Within each 60° sector, that intermediate phase follows the ratio of two sine values. The numerator is an edge sine taken over 0..60°, mirrored on falling sectors. The denominator is an arch sine taken over 60..120°. One quarter-wave sine table supplies both values, so an update needs two table reads and no full three-phase rotation.

Each phase also carries a drive mode. The highest phase is PWM at 100 %. The lowest phase is held low with no PWM. The intermediate phase is PWM in sine mode. When trapezoidal mode is selected, the sine result is not used: the intermediate phase is left floating with duty zero, so its back-EMF can be sensed elsewhere. A one-cycle strobe loads a new angle. The outputs hold between updates.

Top module: `sixstep_duty_gen`

## Requirements
- R1: In sine mode, after every update the highest phase duty is exactly FULL = 2^DUTY_W-1 and the lowest phase duty is exactly 0.
- R2: In sine mode, each phase duty lies within 2 LSB of (x-min)/(max-min)*FULL. Here the phases are x_a=cos θ, x_b=cos(θ-120°) and x_c=cos(θ+120°).
- R3: Sector s selects the phase roles (high, low, intermediate) as follows. s0: a, c, b. s1: b, c, a. s2: b, a, c. s3: c, a, b. s4: c, b, a. s5: a, b, c. The intermediate phase rises in even sectors and falls in odd sectors.
- R4: The angle code is {sector[2:0], pos[POS_W-1:0]}, and θ = (s*2^POS_W + pos)*60°/2^POS_W. Sector codes 6 and 7 give exactly the same outputs as sector codes 0 and 1.
- R5: Mode encoding is 00 = held low, 01 = PWM, 10 = floating. In sine mode the high and intermediate phases are 01 and the low phase is 00.
- R6: In trapezoidal mode the high phase is FULL with mode 01, the low phase is 0 with mode 00, and the intermediate phase is 0 with mode 10.
- R7: When a strobe is sampled at one rising edge, the outputs take the new values at the next rising edge. In that same cycle out_vld is high for exactly one cycle. At all other times the outputs hold.
- R8: While reset is low, all duties are 0, all modes are floating (10), and out_vld is 0.
- R9: A strobe on every cycle produces a fresh result on every cycle, one per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | Load angle and mode select this cycle |
| angle | input | POS_W+3 | Sector (upper 3 bits) and position in sector |
| trap_en | input | 1 | 1 = trapezoidal drive, 0 = sine drive |
| duty_a | output | DUTY_W | Phase a duty |
| duty_b | output | DUTY_W | Phase b duty |
| duty_c | output | DUTY_W | Phase c duty |
| mode_a | output | 2 | Phase a drive mode |
| mode_b | output | 2 | Phase b drive mode |
| mode_c | output | 2 | Phase c drive mode |
| out_vld | output | 1 | One-cycle pulse when outputs update |

## Verification
A wrong sector decode shows up in the very next out_vld cycle. The result is a phase at FULL or 0 that the three-phase reference places elsewhere, or a low or floating mode on the wrong phase. A folding or indexing fault in the sine table shows up only in the intermediate duty. That fault is visible only at positions whose table argument crosses the fold, so the bench sweeps every angle code. A pipeline fault such as a lost stage-one valid or stale table values appears as a missing out_vld pulse, or as a duty that matches the previous strobe, one edge after the strobe was due.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;
    typedef enum logic [1:0] {
        DRV_LOW   = 2'b00,
        DRV_PWM   = 2'b01,
        DRV_FLOAT = 2'b10
    } drv_mode_e;

    localparam int NUM_PH = 3;
endpackage

// File: rtl/sixstep_sine_rom.sv
// Quarter-wave sine table in units of 60deg/2^POS_W, with two read ports.
// Argument range 0..2N; arguments beyond 90deg fold about 90deg.
module sixstep_sine_rom #(
    parameter int POS_W = 8,
    parameter int SIN_W = 14
) (
    input  logic [POS_W+1:0] arg_a,
    input  logic [POS_W+1:0] arg_b,
    output logic [SIN_W-1:0] val_a,
    output logic [SIN_W-1:0] val_b
);
    localparam int N      = 1 << POS_W;
    localparam int DEPTH  = (3 * N) / 2 + 1;
    localparam int IDX_W  = POS_W + 1;
    localparam real SCALE = real'((1 << SIN_W) - 1);
    localparam real STEP  = 3.14159265358979323846 / (3.0 * real'(N));
    localparam logic [POS_W+1:0] QUARTER = (POS_W+2)'((3 * N) / 2);
    localparam logic [POS_W+1:0] HALF    = (POS_W+2)'(3 * N);

    logic [SIN_W-1:0] rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        localparam int VAL = $rtoi($sin(real'(i) * STEP) * SCALE + 0.5);
        assign rom[i] = SIN_W'(VAL);
    end

    function automatic logic [IDX_W-1:0] fold(input logic [POS_W+1:0] a);
        logic [POS_W+1:0] f;
        f = (a > QUARTER) ? (HALF - a) : a;
        return f[IDX_W-1:0];
    endfunction

    assign val_a = rom[fold(arg_a)];
    assign val_b = rom[fold(arg_b)];
endmodule

// File: rtl/sixstep_sector_map.sv
// Sector code to phase roles. Phase index: 0 = a, 1 = b, 2 = c.
module sixstep_sector_map (
    input  logic [2:0] code,
    output logic [1:0] hi_ph,
    output logic [1:0] lo_ph,
    output logic [1:0] mid_ph,
    output logic       rising
);
    logic [2:0] sec;

    always_comb begin
        // codes 6 and 7 alias sectors 0 and 1
        sec = (code >= 3'd6) ? (code - 3'd6) : code;
        rising = ~sec[0];
        unique case (sec)
            3'd0:    begin hi_ph = 2'd0; lo_ph = 2'd2; mid_ph = 2'd1; end
            3'd1:    begin hi_ph = 2'd1; lo_ph = 2'd2; mid_ph = 2'd0; end
            3'd2:    begin hi_ph = 2'd1; lo_ph = 2'd0; mid_ph = 2'd2; end
            3'd3:    begin hi_ph = 2'd2; lo_ph = 2'd0; mid_ph = 2'd1; end
            3'd4:    begin hi_ph = 2'd2; lo_ph = 2'd1; mid_ph = 2'd0; end
            default: begin hi_ph = 2'd0; lo_ph = 2'd1; mid_ph = 2'd2; end
        endcase
    end
endmodule

// File: rtl/sixstep_mid_ratio.sv
// Intermediate duty = round(FULL * edge / arch), clamped to FULL.
module sixstep_mid_ratio #(
    parameter int SIN_W  = 14,
    parameter int DUTY_W = 12
) (
    input  logic [SIN_W-1:0]  edge_val,
    input  logic [SIN_W-1:0]  arch_val,
    output logic [DUTY_W-1:0] ratio
);
    localparam int NUM_W = SIN_W + DUTY_W;
    localparam logic [NUM_W-1:0]  FULL_N = NUM_W'((1 << DUTY_W) - 1);
    localparam logic [DUTY_W-1:0] FULL_D = '1;

    logic [NUM_W-1:0] num;
    logic [NUM_W-1:0] den;
    logic [NUM_W-1:0] quo;

    always_comb begin
        den = NUM_W'(arch_val);
        num = NUM_W'(edge_val) * FULL_N + (den >> 1);
        quo = (den == '0) ? '0 : (num / den);
        ratio = (quo > FULL_N) ? FULL_D : quo[DUTY_W-1:0];
    end
endmodule

// File: rtl/sixstep_duty_gen.sv
module sixstep_duty_gen
    import sixstep_pkg::*;
#(
    parameter int POS_W  = 8,
    parameter int DUTY_W = 12,
    parameter int SIN_W  = 14,
    localparam int ANG_W = POS_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_stb,
    input  logic [ANG_W-1:0]  angle,
    input  logic              trap_en,
    output logic [DUTY_W-1:0] duty_a,
    output logic [DUTY_W-1:0] duty_b,
    output logic [DUTY_W-1:0] duty_c,
    output logic [1:0]        mode_a,
    output logic [1:0]        mode_b,
    output logic [1:0]        mode_c,
    output logic              out_vld
);
    localparam int ARG_W = POS_W + 2;
    localparam logic [ARG_W-1:0]  N_ARG  = ARG_W'(1 << POS_W);
    localparam logic [DUTY_W-1:0] FULL   = '1;

    typedef struct packed {
        logic                          s1_vld;
        logic [1:0]                    hi;
        logic [1:0]                    lo;
        logic [1:0]                    mid;
        logic                          trap;
        logic [SIN_W-1:0]              edge_v;
        logic [SIN_W-1:0]              arch_v;
        logic [NUM_PH-1:0][DUTY_W-1:0] duty;
        logic [NUM_PH-1:0][1:0]        mode;
        logic                          vld;
    } state_t;

    state_t st_d, st_q;

    logic [1:0]        hi_ph, lo_ph, mid_ph;
    logic              rising;
    logic [ARG_W-1:0]  pos_arg;
    logic [ARG_W-1:0]  edge_arg, arch_arg;
    logic [SIN_W-1:0]  edge_val, arch_val;
    logic [DUTY_W-1:0] mid_duty;

    sixstep_sector_map u_map (
        .code   (angle[ANG_W-1 -: 3]),
        .hi_ph  (hi_ph),
        .lo_ph  (lo_ph),
        .mid_ph (mid_ph),
        .rising (rising)
    );

    // rising: edge sin(u), arch sin(u+60); falling mirrors u -> 60-u
    always_comb begin
        pos_arg  = ARG_W'(angle[POS_W-1:0]);
        edge_arg = rising ? pos_arg : (N_ARG - pos_arg);
        arch_arg = rising ? (pos_arg + N_ARG) : ((N_ARG << 1) - pos_arg);
    end

    sixstep_sine_rom #(.POS_W(POS_W), .SIN_W(SIN_W)) u_rom (
        .arg_a (edge_arg),
        .arg_b (arch_arg),
        .val_a (edge_val),
        .val_b (arch_val)
    );

    sixstep_mid_ratio #(.SIN_W(SIN_W), .DUTY_W(DUTY_W)) u_ratio (
        .edge_val (st_q.edge_v),
        .arch_val (st_q.arch_v),
        .ratio    (mid_duty)
    );

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = upd_stb;
        st_d.vld    = st_q.s1_vld;
        if (upd_stb) begin
            st_d.hi   = hi_ph;
            st_d.lo   = lo_ph;
            st_d.mid  = mid_ph;
            st_d.trap = trap_en;
            if (!trap_en) begin
                st_d.edge_v = edge_val;
                st_d.arch_v = arch_val;
            end
        end
        if (st_q.s1_vld) begin
            for (int p = 0; p < NUM_PH; p++) begin
                if (2'(p) == st_q.hi) begin
                    st_d.duty[p] = FULL;
                    st_d.mode[p] = DRV_PWM;
                end else if (2'(p) == st_q.lo) begin
                    st_d.duty[p] = '0;
                    st_d.mode[p] = DRV_LOW;
                end else if (st_q.trap) begin
                    st_d.duty[p] = '0;
                    st_d.mode[p] = DRV_FLOAT;
                end else begin
                    st_d.duty[p] = mid_duty;
                    st_d.mode[p] = DRV_PWM;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= {NUM_PH{DRV_FLOAT}};
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_a  = st_q.duty[0];
    assign duty_b  = st_q.duty[1];
    assign duty_c  = st_q.duty[2];
    assign mode_a  = st_q.mode[0];
    assign mode_b  = st_q.mode[1];
    assign mode_c  = st_q.mode[2];
    assign out_vld = st_q.vld;
endmodule

// File: rtl/sixstep_duty_gen_chk.sv
module sixstep_duty_gen_chk
    import sixstep_pkg::*;
#(
    parameter int DUTY_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_stb,
    input logic [DUTY_W-1:0] duty_a,
    input logic [DUTY_W-1:0] duty_b,
    input logic [DUTY_W-1:0] duty_c,
    input logic [1:0]        mode_a,
    input logic [1:0]        mode_b,
    input logic [1:0]        mode_c,
    input logic              out_vld
);
    localparam logic [DUTY_W-1:0] FULL = '1;

    AST_LOW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (duty_a == '0 || duty_b == '0 || duty_c == '0)); // R1

    AST_HIGH_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (duty_a == FULL || duty_b == FULL || duty_c == FULL)); // R1

    AST_ONE_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $countones({mode_a == DRV_LOW, mode_b == DRV_LOW, mode_c == DRV_LOW}) == 1); // R5

    AST_FLOAT_NO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((mode_a != DRV_FLOAT || duty_a == '0) &&
                     (mode_b != DRV_FLOAT || duty_b == '0) &&
                     (mode_c != DRV_FLOAT || duty_c == '0))); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> ($stable(duty_a) && $stable(duty_b) && $stable(duty_c) &&
                      $stable(mode_a) && $stable(mode_b) && $stable(mode_c))); // R7

    AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(upd_stb, 2)); // R7
endmodule

bind sixstep_duty_gen sixstep_duty_gen_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_stb (upd_stb),
    .duty_a  (duty_a),
    .duty_b  (duty_b),
    .duty_c  (duty_c),
    .mode_a  (mode_a),
    .mode_b  (mode_b),
    .mode_c  (mode_c),
    .out_vld (out_vld)
);

// File: tb/sixstep_duty_gen_tb_top.sv
module sixstep_duty_gen_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  POS_W  = 8;
    localparam int  DUTY_W = 12;
    localparam int  SIN_W  = 14;
    localparam int  ANG_W  = POS_W + 3;
    localparam int  N      = 1 << POS_W;
    localparam int  FULL   = (1 << DUTY_W) - 1;
    localparam int  TOL    = 2;
    localparam real PI     = 3.14159265358979323846;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              upd_stb = 1'b0;
    logic [ANG_W-1:0]  angle = '0;
    logic              trap_en = 1'b0;
    logic [DUTY_W-1:0] duty_a, duty_b, duty_c;
    logic [1:0]        mode_a, mode_b, mode_c;
    logic              out_vld;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    bit  cmp_en  = 0;
    int  vld_cnt = 0;

    // reference model state
    bit  p1_v = 0;
    int  p1_code = 0;
    bit  p1_trap = 0;
    real exp_d [3] = '{0.0, 0.0, 0.0};
    int  exp_tol [3] = '{0, 0, 0};
    int  exp_m [3] = '{2, 2, 2};
    string exp_tag_d [3] = '{"R8", "R8", "R8"};
    string exp_tag_m [3] = '{"R8", "R8", "R8"};
    bit  exp_v = 0;

    int HI_TAB [6] = '{0, 1, 1, 2, 2, 0};
    int LO_TAB [6] = '{2, 2, 0, 0, 1, 1};

    always #(CLK_PERIOD/2) clk = ~clk;

    sixstep_duty_gen #(.POS_W(POS_W), .DUTY_W(DUTY_W), .SIN_W(SIN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .angle(angle), .trap_en(trap_en),
        .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
        .mode_a(mode_a), .mode_b(mode_b), .mode_c(mode_c), .out_vld(out_vld)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
        end
    endtask

    task automatic set_exp(input int code, input bit trap);
        int  s = (code >> POS_W) % 6;
        int  p = code % N;
        real th = real'(s * N + p) * 2.0 * PI / (6.0 * real'(N));
        real x [3];
        real mn, mx;
        x[0] = $cos(th);
        x[1] = $cos(th - 2.0 * PI / 3.0);
        x[2] = $cos(th + 2.0 * PI / 3.0);
        mn = x[0]; mx = x[0];
        for (int k = 1; k < 3; k++) begin
            if (x[k] < mn) mn = x[k];
            if (x[k] > mx) mx = x[k];
        end
        for (int k = 0; k < 3; k++) begin
            if (k == HI_TAB[s]) begin
                exp_d[k] = real'(FULL); exp_tol[k] = 0; exp_m[k] = 1;
                exp_tag_d[k] = "R1"; exp_tag_m[k] = trap ? "R6" : "R5";
            end else if (k == LO_TAB[s]) begin
                exp_d[k] = 0.0; exp_tol[k] = 0; exp_m[k] = 0;
                exp_tag_d[k] = "R1"; exp_tag_m[k] = trap ? "R6" : "R5";
            end else if (trap) begin
                exp_d[k] = 0.0; exp_tol[k] = 0; exp_m[k] = 2;
                exp_tag_d[k] = "R6"; exp_tag_m[k] = "R6";
            end else begin
                exp_d[k] = (x[k] - mn) / (mx - mn) * real'(FULL);
                exp_tol[k] = TOL; exp_m[k] = 1;
                exp_tag_d[k] = "R2"; exp_tag_m[k] = "R3";
            end
        end
    endtask

    // cycle model: strobe sampled at edge k -> outputs at edge k+1 (R7)
    always @(posedge clk) begin
        if (!rst_n) begin
            p1_v = 0;
            exp_v = 0;
            for (int k = 0; k < 3; k++) begin
                exp_d[k] = 0.0; exp_tol[k] = 0; exp_m[k] = 2;
                exp_tag_d[k] = "R8"; exp_tag_m[k] = "R8";
            end
        end else begin
            if (p1_v) set_exp(p1_code, p1_trap);
            exp_v = p1_v;
            p1_v = upd_stb;
            p1_code = int'(angle);
            p1_trap = trap_en;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            int act_d [3];
            int act_m [3];
            real diff;
            act_d = '{int'(duty_a), int'(duty_b), int'(duty_c)};
            act_m = '{int'(mode_a), int'(mode_b), int'(mode_c)};
            check(out_vld == exp_v, "R7", int'(out_vld), int'(exp_v));
            if (out_vld) vld_cnt++;
            for (int k = 0; k < 3; k++) begin
                diff = real'(act_d[k]) - exp_d[k];
                if (diff < 0.0) diff = -diff;
                check(diff <= real'(exp_tol[k]) + 0.5 * (exp_tol[k] == 0 ? 0.0 : 1.0) - (exp_tol[k] == 0 ? 0.0 : 0.5),
                      exp_tag_d[k], act_d[k], $rtoi(exp_d[k] + 0.5));
                check(act_m[k] == exp_m[k], exp_tag_m[k], act_m[k], exp_m[k]);
            end
        end
    end

    task automatic strobe(input int code, input bit trap);
        @(negedge clk);
        upd_stb = 1'b1;
        angle   = ANG_W'(code);
        trap_en = trap;
        @(negedge clk);
        upd_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R7 actual=0 expected=1");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int sv_d [3];
        int strobes;
        // R8: reset state
        idle(3);
        check(duty_a == 0 && duty_b == 0 && duty_c == 0, "R8", int'(duty_a) + int'(duty_b) + int'(duty_c), 0);
        check(mode_a == 2'b10 && mode_b == 2'b10 && mode_c == 2'b10, "R8", int'({mode_a, mode_b, mode_c}), 'b101010);
        check(out_vld == 1'b0, "R8", int'(out_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1;
        idle(2);

        // R1 R2 R3 R5: spaced updates across every sector and sector edges
        for (int s = 0; s < 6; s++) begin
            int pl [5] = '{0, 1, N / 2, N - 1, 77};
            for (int j = 0; j < 5; j++) begin
                strobe(s * N + pl[j], 1'b0);
                idle(2);
            end
        end

        // R6: trapezoidal drive in every sector
        for (int s = 0; s < 6; s++) begin
            strobe(s * N + 40, 1'b1);
            idle(1);
        end
        strobe(2 * N + 9, 1'b0);
        idle(2);

        // R4: sector codes 6 and 7 alias 0 and 1
        for (int w = 0; w < 2; w++) begin
            strobe(w * N + 37, 1'b0);
            idle(2);
            sv_d = '{int'(duty_a), int'(duty_b), int'(duty_c)};
            strobe((w + 6) * N + 37, 1'b0);
            idle(2);
            check(int'(duty_a) == sv_d[0], "R4", int'(duty_a), sv_d[0]);
            check(int'(duty_b) == sv_d[1], "R4", int'(duty_b), sv_d[1]);
            check(int'(duty_c) == sv_d[2], "R4", int'(duty_c), sv_d[2]);
        end

        // R9: a strobe every cycle over every angle code
        idle(3);
        vld_cnt = 0;
        strobes = 0;
        for (int c = 0; c < 8 * N; c++) begin
            @(negedge clk);
            upd_stb = 1'b1;
            angle   = ANG_W'(c);
            trap_en = (c % 97) == 5;
            strobes++;
        end
        @(negedge clk);
        upd_stb = 1'b0;
        idle(4);
        check(vld_cnt == strobes, "R9", vld_cnt, strobes);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule